// File: doc/BRIEF.md
# Memory Chip-Enable Gate

This block sits between a processor's active-low memory chip-enable and a battery-backed memory. While the supervised system reset is released, the chip-enable passes through combinationally. When that reset asserts, the path is shut so that no write can reach the memory while the supply is failing. The output is then held at its inactive high level.

A write cycle that is in flight when reset arrives is not cut short. If the chip-enable is low at that moment, the gate stays open until one of two things happens: the processor lifts the chip-enable, or a grace window of `GRACE_TICKS` pulses on `tick_i` has elapsed. The first of the two closes the gate. A three-state controller holds the mode in a register, and a combinational select drives the output.

Top module: `ce_gate_ctrl`

## Requirements
- R1: While the controller is open and `sys_rst_ni` is high, `ce_no` equals `ce_ni` in the same cycle and `gate_en_o` is 1.
- R2: If `sys_rst_ni` falls while `ce_ni` is 1, `gate_en_o` drops to 0 in that same cycle, without waiting for a clock edge.
- R3: If `sys_rst_ni` falls while `ce_ni` is 0, the gate stays open (`gate_en_o`=1, `ce_no`=0) until `ce_ni` rises. It closes in the cycle where `ce_ni` is seen high.
- R4: While the gate is closed, `ce_no` is 1 whatever the value of `ce_ni`.
- R5: During a grace window with `tick_i` high every cycle, the gate closes at the clock edge on which the `GRACE_TICKS`-th tick is sampled. The count starts at the first edge after the one that entered the window.
- R6: Clock edges on which `tick_i` is 0 do not advance the grace window.
- R7: Once closed, the gate stays closed for as long as `sys_rst_ni` stays low.
- R8: The gate reopens on the first clock edge that samples `sys_rst_ni` high, and not before. From that cycle on, `ce_no` follows `ce_ni`, including a low level.
- R9: If `sys_rst_ni` rises during a grace window, the controller goes straight back to open and clears the grace count. A later grace window therefore lasts the full `GRACE_TICKS`.
- R10: While `rst_ni` is low, the controller is closed: `gate_en_o`=0 and `ce_no`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| tick_i | input | 1 | Timebase pulse that advances the grace window |
| sys_rst_ni | input | 1 | Supervised system reset, active low |
| ce_ni | input | 1 | Chip-enable from the processor, active low |
| ce_no | output | 1 | Gated chip-enable to the memory, active low |
| gate_en_o | output | 1 | 1 while the gate passes the chip-enable |

## Verification
The bench builds the block with `GRACE_TICKS` set to 4 and drives `tick_i` itself. A timeout therefore takes a handful of cycles, and an off-by-one in the grace count shows up as an output that changes one edge early or one edge late. Holding `tick_i` low for several windows checks that plain clock edges are not counted. Releasing reset partway through a window and then asserting it again separates a count that was cleared from a count left over from before.

// File: rtl/ceg_pkg.sv
package ceg_pkg;
  typedef enum logic [1:0] {
    ST_OPEN   = 2'd0,
    ST_GRACE  = 2'd1,
    ST_CLOSED = 2'd2
  } ceg_state_e;
endpackage

// File: rtl/ceg_grace_timer.sv
module ceg_grace_timer #(
  parameter int unsigned GRACE_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = (GRACE_TICKS > 1) ? $clog2(GRACE_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GRACE_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (run_i && tick_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && tick_i && (cnt_q == LAST);

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R5

  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/ceg_fsm.sv
module ceg_fsm
  import ceg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sys_rst_ni,
  input  logic       ce_ni,
  input  logic       expire_i,
  output ceg_state_e state_o
);
  ceg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OPEN: begin
        if (!sys_rst_ni) state_d = ce_ni ? ST_CLOSED : ST_GRACE;
      end
      ST_GRACE: begin
        if (sys_rst_ni)              state_d = ST_OPEN;
        else if (ce_ni || expire_i)  state_d = ST_CLOSED;
      end
      ST_CLOSED: begin
        if (sys_rst_ni) state_d = ST_OPEN;
      end
      default: state_d = ST_CLOSED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_CLOSED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_IDLE_CE_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPEN && !sys_rst_ni && ce_ni) |=> state_q == ST_CLOSED); // R2

  AST_STAY_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CLOSED && !sys_rst_ni) |=> state_q == ST_CLOSED); // R7

  AST_REOPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_OPEN && sys_rst_ni) |=> state_q == ST_OPEN); // R8
endmodule

// File: rtl/ceg_out_gate.sv
module ceg_out_gate
  import ceg_pkg::*;
(
  input  ceg_state_e state_i,
  input  logic       sys_rst_ni,
  input  logic       ce_ni,
  output logic       open_o,
  output logic       ce_no
);
  // open: close at once if reset lands on an idle chip-enable
  always_comb begin
    unique case (state_i)
      ST_OPEN:  open_o = sys_rst_ni || !ce_ni;
      ST_GRACE: open_o = !ce_ni;
      default:  open_o = 1'b0;
    endcase
  end

  assign ce_no = open_o ? ce_ni : 1'b1;
endmodule

// File: rtl/ce_gate_ctrl.sv
module ce_gate_ctrl
  import ceg_pkg::*;
#(
  parameter int unsigned GRACE_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sys_rst_ni,
  input  logic ce_ni,
  output logic ce_no,
  output logic gate_en_o
);
  ceg_state_e state;
  logic       expire;
  logic       in_grace;

  assign in_grace = (state == ST_GRACE);

  ceg_grace_timer #(.GRACE_TICKS(GRACE_TICKS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!in_grace || sys_rst_ni),
    .run_i   (in_grace && !sys_rst_ni),
    .tick_i  (tick_i),
    .expire_o(expire)
  );

  ceg_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_rst_ni(sys_rst_ni),
    .ce_ni     (ce_ni),
    .expire_i  (expire),
    .state_o   (state)
  );

  ceg_out_gate u_gate (
    .state_i   (state),
    .sys_rst_ni(sys_rst_ni),
    .ce_ni     (ce_ni),
    .open_o    (gate_en_o),
    .ce_no     (ce_no)
  );

  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_OPEN && sys_rst_ni) |-> (ce_no == ce_ni && gate_en_o)); // R1

  AST_CLOSED_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_CLOSED) |-> ce_no); // R4

  AST_GRACE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_grace && sys_rst_ni) |=> (state == ST_OPEN)); // R9
endmodule

// File: tb/ce_gate_ctrl_test.sv
`timescale 1ns/1ps
module ce_gate_ctrl_test;
  localparam int GT = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic sys_rst_ni = 1'b0;
  logic ce_ni = 1'b1;
  logic ce_no, gate_en_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ce_gate_ctrl #(.GRACE_TICKS(GT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .sys_rst_ni(sys_rst_ni),
    .ce_ni(ce_ni), .ce_no(ce_no), .gate_en_o(gate_en_o)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic reopen();
    @(negedge clk); sys_rst_ni = 1'b1; ce_ni = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); ce_ni = 1'b0; #1;
    chk("R10 ce_no", ce_no, 1'b1);
    chk("R10 gate_en", gate_en_o, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk); #1;
    chk("R7 closed after block reset", ce_no, 1'b1);
  endtask

  task automatic t_release();
    @(negedge clk); sys_rst_ni = 1'b1; ce_ni = 1'b0; #1;
    chk("R8 not before edge", ce_no, 1'b1);
    @(negedge clk); #1;
    chk("R8 low passes on reopen", ce_no, 1'b0);
    chk("R8 gate_en", gate_en_o, 1'b1);
  endtask

  task automatic t_pass();
    logic [3:0] pat = 4'b1010;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ce_ni = pat[i]; #1;
      chk("R1 follow", ce_no, pat[i]);
      chk("R1 gate_en", gate_en_o, 1'b1);
    end
  endtask

  task automatic t_close_idle();
    @(negedge clk); ce_ni = 1'b1; sys_rst_ni = 1'b0; #1;
    chk("R2 same-cycle close", gate_en_o, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ce_ni = i[0]; #1;
      chk("R4 held high", ce_no, 1'b1);
      chk("R7 stays closed", gate_en_o, 1'b0);
    end
    t_release();
  endtask

  task automatic t_grace_rise();
    tick_i = 1'b0;
    @(negedge clk); ce_ni = 1'b0; sys_rst_ni = 1'b0; #1;
    chk("R3 open in write", gate_en_o, 1'b1);
    chk("R3 write low", ce_no, 1'b0);
    repeat (2) @(negedge clk);
    #1 chk("R3 still open", ce_no, 1'b0);
    @(negedge clk); ce_ni = 1'b1; #1;
    chk("R3 close on rise", gate_en_o, 1'b0);
    @(negedge clk); ce_ni = 1'b0; #1;
    chk("R4 no second write", ce_no, 1'b1);
    reopen();
  endtask

  task automatic t_timeout();
    tick_i = 1'b1;
    @(negedge clk); ce_ni = 1'b0; sys_rst_ni = 1'b0;
    repeat (GT) @(negedge clk);
    #1 chk("R5 open before last tick", ce_no, 1'b0);
    @(negedge clk); #1;
    chk("R5 closed at expiry", ce_no, 1'b1);
    chk("R5 gate_en", gate_en_o, 1'b0);
    reopen();
  endtask

  task automatic t_no_tick();
    tick_i = 1'b0;
    @(negedge clk); ce_ni = 1'b0; sys_rst_ni = 1'b0;
    repeat (3 * GT) @(negedge clk);
    #1 chk("R6 no ticks no expiry", ce_no, 1'b0);
    @(negedge clk); tick_i = 1'b1;
    repeat (GT - 1) @(negedge clk);
    #1 chk("R6 ticks count from here", ce_no, 1'b0);
    @(negedge clk); #1;
    chk("R6 expiry after ticks", ce_no, 1'b1);
    reopen();
  endtask

  task automatic t_release_in_grace();
    tick_i = 1'b1;
    @(negedge clk); ce_ni = 1'b0; sys_rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk); sys_rst_ni = 1'b1;
    @(negedge clk); #1;
    chk("R9 back to open", gate_en_o, 1'b1);
    sys_rst_ni = 1'b0;
    repeat (GT) @(negedge clk);
    #1 chk("R9 full window again", ce_no, 1'b0);
    @(negedge clk); #1;
    chk("R9 expiry after full window", ce_no, 1'b1);
    reopen();
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_release();
    t_pass();
    t_close_idle();
    t_grace_rise();
    t_timeout();
    t_no_tick();
    t_release_in_grace();
    t_pass();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule